// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block sits behind the bit-level receiver of an I2C target and decides, byte by byte, whether the local device is the one being addressed. After every START or repeated START it examines the address phase. In 7-bit mode that phase is a single byte. In extended mode it is a header byte followed by a low-address byte. The block then reports a match, the direction of the transfer that follows, and whether the receiver should drive ACK for the byte just taken in.

Software sets up the candidates through plain configuration inputs:

- a primary address;
- an optional second address, which becomes the inclusive top of an accepted window when window mode is on;
- an enable for the all-zero broadcast address.

The bit shifter, clock stretching, rate generation and pad logic are outside this block. It only sees a byte strobe, START and STOP pulses, and the configuration.

Top module: `i2c_addr_match`

## Requirements
- R1: While reset is held and on the first cycle after it, `match_o`, `dir_tx_o` and `ack_o` are all 0.
- R2: In 7-bit mode, a first byte after START whose bits 7..1 equal `prim_addr_i[6:0]` sets `match_o` and `ack_o` on the cycle after the strobe. `dir_tx_o` takes byte bit 0 (1 = the target transmits) and is never 1 while `match_o` is 0.
- R3: With window mode off, a nonzero `upper_addr_i` is a second single 7-bit address. An `upper_addr_i` of 0 matches nothing.
- R4: With window mode on and `upper_addr_i` nonzero, an address A in bits 7..1 matches when `prim_addr_i[6:0]` < A <= `upper_addr_i`. The primary address itself still matches.
- R5: When `gcall_en_i` is 1, the byte 0x00 matches with direction 0. The byte 0x01 never matches as a broadcast, and 0x00 is not matched when `gcall_en_i` is 0.
- R6: In extended mode, the first byte must be binary 11110, then `prim_addr_i[9:8]`, then the R/W bit. Such a header is acknowledged (`ack_o` = 1) without setting `match_o`. The next byte equal to `prim_addr_i[7:0]` sets `match_o`, sets `ack_o`, and sets `dir_tx_o` from the header's R/W bit.
- R7: In extended mode with `upper_addr_i` nonzero, a low byte equal to {`prim_addr_i[7]`, `upper_addr_i`} also matches. This is the second 10-bit address formed from the primary's top three bits and the upper register.
- R8: STOP or a new START clears `match_o`, `dir_tx_o` and `ack_o` on the following cycle. Bytes received before any START, or after the address phase has completed, change nothing. While no START or STOP arrives, `match_o` holds.
- R9: An address byte that matches no candidate leaves `ack_o` and `match_o` at 0. This includes a wrong header and a wrong low byte in extended mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle pulse: START or repeated START seen on the bus |
| stop_i | input | 1 | One-cycle pulse: STOP seen on the bus |
| byte_vld_i | input | 1 | One-cycle strobe: `byte_i` holds a complete received byte |
| byte_i | input | 8 | Received byte, MSB first on the wire |
| ext_mode_i | input | 1 | 1 selects 10-bit addressing |
| range_en_i | input | 1 | 1 turns the upper address into a window bound |
| gcall_en_i | input | 1 | 1 accepts the broadcast address |
| prim_addr_i | input | 10 | Primary address; the 7-bit mode uses bits 6..0 |
| upper_addr_i | input | 7 | Upper/second address; 0 disables it |
| match_o | output | 1 | The local target is addressed in this transfer |
| dir_tx_o | output | 1 | 1 when the target transmits (master reads) |
| ack_o | output | 1 | One-cycle request to ACK the byte just received |

## Verification
The bench builds the block with its default parameters: an 8-bit byte, a broadcast value of 0x00 and the 11110 header tag. With these defaults every candidate path can be reached.

Directed scenarios cover the following:

- window edges one step below the primary, at the primary, at the top bound and one step above it;
- broadcast acceptance with both R/W values and with the enable off;
- both 10-bit addresses in write and read form.

Each scenario starts from a fresh START, so clearing on START and STOP is exercised between every pair of scenarios.

// File: rtl/i2cam_pkg.sv
// Package: shared widths and the address-phase state encoding of the
// slave address matcher. Assumes a byte-oriented receiver in front.
package i2cam_pkg;
    localparam int BYTE_W = 8;
    localparam int A7_W   = 7;
    localparam int A10_W  = 10;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // no START seen since reset or STOP
        ST_ADDR = 2'd1,   // next byte is the first address byte
        ST_LOW  = 2'd2,   // extended header accepted, low byte next
        ST_HOLD = 2'd3    // address phase over, data bytes ignored
    } am_state_e;
endpackage

// File: rtl/i2cam_cmp7.sv
// Module: single-byte address comparator. Tests bits 7..1 of the received
// byte against the primary address, the upper address (single or as a
// window top) and the broadcast byte. Purely combinational.
// Assumes the upper address is programmed above the primary in window mode.
module i2cam_cmp7 #(
    parameter int          BYTE_W     = 8,
    parameter int          A7_W       = 7,
    parameter logic [7:0]  GCALL_BYTE = 8'h00
) (
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [A7_W-1:0]   prim7_i,
    input  logic [A7_W-1:0]   upper7_i,
    input  logic              range_en_i,
    input  logic              gcall_en_i,
    output logic              hit_o,
    output logic              gc_hit_o
);
    logic [A7_W-1:0] rx_addr;
    logic            prim_eq;
    logic            upper_on;
    logic            upper_eq;
    logic            in_window;

    // Compare the incoming address with every 7-bit candidate.
    always_comb begin
        rx_addr   = byte_i[BYTE_W-1:1];
        prim_eq   = (rx_addr == prim7_i);
        upper_on  = (upper7_i != '0);
        upper_eq  = upper_on && !range_en_i && (rx_addr == upper7_i);
        in_window = upper_on && range_en_i &&
                    (rx_addr > prim7_i) && (rx_addr <= upper7_i);
        gc_hit_o  = gcall_en_i && (byte_i == GCALL_BYTE[BYTE_W-1:0]);
        hit_o     = prim_eq || upper_eq || in_window || gc_hit_o;
    end
endmodule

// File: rtl/i2cam_cmp10.sv
// Module: extended-address comparator. Checks the header byte (tag plus
// the two top address bits) and the low byte against the primary and the
// second 10-bit address. Purely combinational; sequencing lives in the top.
module i2cam_cmp10 #(
    parameter int         BYTE_W  = 8,
    parameter int         A7_W    = 7,
    parameter int         A10_W   = 10,
    parameter logic [4:0] HDR_TAG = 5'b11110
) (
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [A10_W-1:0]  prim10_i,
    input  logic [A7_W-1:0]   upper7_i,
    output logic              hdr_ok_o,
    output logic              low_hit_o
);
    localparam int TAG_W = BYTE_W - 3;
    localparam int HI_W  = A10_W - BYTE_W;

    logic [BYTE_W-1:0] sec_low;

    // Header check and low-byte check against both 10-bit candidates.
    always_comb begin
        sec_low   = {prim10_i[A7_W], upper7_i};
        hdr_ok_o  = (byte_i[BYTE_W-1 -: TAG_W] == HDR_TAG[TAG_W-1:0]) &&
                    (byte_i[HI_W:1] == prim10_i[A10_W-1:BYTE_W]);
        low_hit_o = (byte_i == prim10_i[BYTE_W-1:0]) ||
                    ((upper7_i != '0) && (byte_i == sec_low));
    end
endmodule

// File: rtl/i2c_addr_match.sv
// Module: I2C target address matcher (top). Tracks the address phase after
// each START, registers the match and direction, and pulses an ACK request
// for each accepted address byte. Assumes START/STOP/byte strobes are
// single-cycle and mutually ordered by the bit-level receiver.
module i2c_addr_match
    import i2cam_pkg::*;
#(
    parameter logic [7:0] GCALL_BYTE = 8'h00,
    parameter logic [4:0] HDR_TAG    = 5'b11110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              byte_vld_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              ext_mode_i,
    input  logic              range_en_i,
    input  logic              gcall_en_i,
    input  logic [A10_W-1:0]  prim_addr_i,
    input  logic [A7_W-1:0]   upper_addr_i,
    output logic              match_o,
    output logic              dir_tx_o,
    output logic              ack_o
);
    am_state_e state_q;
    logic      rw_q;
    logic      hit7;
    logic      gc_hit;
    logic      hdr_ok;
    logic      low_hit;

    i2cam_cmp7 #(
        .BYTE_W     (BYTE_W),
        .A7_W       (A7_W),
        .GCALL_BYTE (GCALL_BYTE)
    ) u_cmp7 (
        .byte_i     (byte_i),
        .prim7_i    (prim_addr_i[A7_W-1:0]),
        .upper7_i   (upper_addr_i),
        .range_en_i (range_en_i),
        .gcall_en_i (gcall_en_i),
        .hit_o      (hit7),
        .gc_hit_o   (gc_hit)
    );

    i2cam_cmp10 #(
        .BYTE_W  (BYTE_W),
        .A7_W    (A7_W),
        .A10_W   (A10_W),
        .HDR_TAG (HDR_TAG)
    ) u_cmp10 (
        .byte_i    (byte_i),
        .prim10_i  (prim_addr_i),
        .upper7_i  (upper_addr_i),
        .hdr_ok_o  (hdr_ok),
        .low_hit_o (low_hit)
    );

    // Address-phase sequencer with registered match, direction and ACK.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            rw_q     <= 1'b0;
            match_o  <= 1'b0;
            dir_tx_o <= 1'b0;
            ack_o    <= 1'b0;
        end else begin
            ack_o <= 1'b0;
            if (start_i) begin
                state_q  <= ST_ADDR;
                match_o  <= 1'b0;
                dir_tx_o <= 1'b0;
            end else if (stop_i) begin
                state_q  <= ST_IDLE;
                match_o  <= 1'b0;
                dir_tx_o <= 1'b0;
            end else if (byte_vld_i) begin
                case (state_q)
                    ST_ADDR: begin
                        if (!ext_mode_i) begin
                            match_o  <= hit7;
                            dir_tx_o <= hit7 && byte_i[0];
                            ack_o    <= hit7;
                            state_q  <= ST_HOLD;
                        end else if (hdr_ok) begin
                            ack_o   <= 1'b1;
                            rw_q    <= byte_i[0];
                            state_q <= ST_LOW;
                        end else if (gc_hit) begin
                            match_o  <= 1'b1;
                            dir_tx_o <= 1'b0;
                            ack_o    <= 1'b1;
                            state_q  <= ST_HOLD;
                        end else begin
                            state_q <= ST_HOLD;
                        end
                    end
                    ST_LOW: begin
                        match_o  <= low_hit;
                        dir_tx_o <= low_hit && rw_q;
                        ack_o    <= low_hit;
                        state_q  <= ST_HOLD;
                    end
                    default: begin
                        state_q <= state_q;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/i2cam_chk.sv
// Module: property checker for the address matcher, attached by bind.
module i2cam_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic stop_i,
    input logic byte_vld_i,
    input logic match_o,
    input logic dir_tx_o,
    input logic ack_o
);
    // R2: a transmit direction is only reported for a matched transfer
    a_r2_dir_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
        dir_tx_o |-> match_o);

    // R2: a match only rises after a received byte
    a_r2_match_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match_o) |-> ($past(byte_vld_i) && !$past(start_i)));

    // R9: ACK is only requested for a byte just received
    a_r9_ack_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> $past(byte_vld_i));

    // R8: START clears everything
    a_r8_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!match_o && !dir_tx_o && !ack_o));

    // R8: STOP clears everything
    a_r8_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (!match_o && !dir_tx_o && !ack_o));

    // R8: a match persists until START or STOP
    a_r8_match_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (match_o && !start_i && !stop_i) |=> match_o);
endmodule

bind i2c_addr_match i2cam_chk u_i2cam_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .stop_i     (stop_i),
    .byte_vld_i (byte_vld_i),
    .match_o    (match_o),
    .dir_tx_o   (dir_tx_o),
    .ack_o      (ack_o)
);

// File: tb/test_i2c_addr_match.sv
module test_i2c_addr_match;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       stop_i = 1'b0;
    logic       byte_vld_i = 1'b0;
    logic [7:0] byte_i = 8'h00;
    logic       ext_mode_i = 1'b0;
    logic       range_en_i = 1'b0;
    logic       gcall_en_i = 1'b0;
    logic [9:0] prim_addr_i = 10'h000;
    logic [6:0] upper_addr_i = 7'h00;
    logic       match_o;
    logic       dir_tx_o;
    logic       ack_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    i2c_addr_match i_i2c_addr_match (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .stop_i       (stop_i),
        .byte_vld_i   (byte_vld_i),
        .byte_i       (byte_i),
        .ext_mode_i   (ext_mode_i),
        .range_en_i   (range_en_i),
        .gcall_en_i   (gcall_en_i),
        .prim_addr_i  (prim_addr_i),
        .upper_addr_i (upper_addr_i),
        .match_o      (match_o),
        .dir_tx_o     (dir_tx_o),
        .ack_o        (ack_o)
    );

    task automatic chk(string tag, logic [2:0] act, logic [2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {ack,match,dir} got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask

    task automatic bus_stop();
        @(negedge clk) stop_i = 1'b1;
        @(negedge clk) stop_i = 1'b0;
    endtask

    // Send one byte, then check outputs one cycle later.
    task automatic put(string tag, logic [7:0] b, logic e_ack, logic e_m, logic e_d);
        @(negedge clk) begin byte_vld_i = 1'b1; byte_i = b; end
        @(negedge clk) byte_vld_i = 1'b0;
        chk(tag, {ack_o, match_o, dir_tx_o}, {e_ack, e_m, e_d});
    endtask

    task automatic t_reset();
        chk("R1 reset held", {ack_o, match_o, dir_tx_o}, 3'b000);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", {ack_o, match_o, dir_tx_o}, 3'b000);
    endtask

    task automatic t_prim7();
        prim_addr_i = 10'h028;
        put("R8 byte before START", 8'h50, 1'b0, 1'b0, 1'b0);
        bus_start();
        put("R2 primary read", 8'h51, 1'b1, 1'b1, 1'b1);
        @(negedge clk);
        chk("R8 ack one cycle, match held", {ack_o, match_o, dir_tx_o}, 3'b011);
        put("R8 data byte ignored", 8'h00, 1'b0, 1'b1, 1'b1);
        bus_stop();
        chk("R8 stop clears", {ack_o, match_o, dir_tx_o}, 3'b000);
        bus_start();
        put("R2 primary write", 8'h50, 1'b1, 1'b1, 1'b0);
        bus_start();
        chk("R8 restart clears", {ack_o, match_o, dir_tx_o}, 3'b000);
        put("R9 other address", 8'h52, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_upper();
        upper_addr_i = 7'h30;
        bus_start(); put("R3 second address", 8'h61, 1'b1, 1'b1, 1'b1);
        bus_start(); put("R9 between addresses", 8'h58, 1'b0, 1'b0, 1'b0);
        upper_addr_i = 7'h00;
        bus_start(); put("R3 upper zero disables", 8'h00, 1'b0, 1'b0, 1'b0);
        bus_start(); put("R3 upper zero old value", 8'h60, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_range();
        upper_addr_i = 7'h30; range_en_i = 1'b1;
        bus_start(); put("R4 window below primary", 8'h4E, 1'b0, 1'b0, 1'b0);
        bus_start(); put("R4 window primary", 8'h50, 1'b1, 1'b1, 1'b0);
        bus_start(); put("R4 window inside", 8'h53, 1'b1, 1'b1, 1'b1);
        bus_start(); put("R4 window top", 8'h60, 1'b1, 1'b1, 1'b0);
        bus_start(); put("R4 window above", 8'h62, 1'b0, 1'b0, 1'b0);
        upper_addr_i = 7'h00;
        bus_start(); put("R4 window off with zero upper", 8'h52, 1'b0, 1'b0, 1'b0);
        range_en_i = 1'b0;
    endtask

    task automatic t_gcall();
        bus_start(); put("R5 broadcast disabled", 8'h00, 1'b0, 1'b0, 1'b0);
        gcall_en_i = 1'b1;
        bus_start(); put("R5 broadcast write", 8'h00, 1'b1, 1'b1, 1'b0);
        bus_start(); put("R5 broadcast read rejected", 8'h01, 1'b0, 1'b0, 1'b0);
        gcall_en_i = 1'b0;
    endtask

    task automatic t_ext();
        ext_mode_i = 1'b1; prim_addr_i = 10'h2A5; upper_addr_i = 7'h00;
        bus_start();
        put("R6 header acked", 8'hF4, 1'b1, 1'b0, 1'b0);
        put("R6 low write", 8'hA5, 1'b1, 1'b1, 1'b0);
        bus_start();
        put("R6 read header", 8'hF5, 1'b1, 1'b0, 1'b0);
        put("R6 low read", 8'hA5, 1'b1, 1'b1, 1'b1);
        bus_start();
        put("R6 header", 8'hF4, 1'b1, 1'b0, 1'b0);
        put("R9 wrong low", 8'hA6, 1'b0, 1'b0, 1'b0);
        bus_start(); put("R9 wrong header bits", 8'hF2, 1'b0, 1'b0, 1'b0);
        bus_start(); put("R6 7-bit form ignored", 8'h4A, 1'b0, 1'b0, 1'b0);
        bus_start();
        put("R7 header", 8'hF4, 1'b1, 1'b0, 1'b0);
        put("R7 second disabled", 8'h9E, 1'b0, 1'b0, 1'b0);
        upper_addr_i = 7'h1E;
        bus_start();
        put("R7 header", 8'hF5, 1'b1, 1'b0, 1'b0);
        put("R7 second address", 8'h9E, 1'b1, 1'b1, 1'b1);
        bus_stop();
        chk("R8 stop clears extended", {ack_o, match_o, dir_tx_o}, 3'b000);
        ext_mode_i = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_prim7();
        t_upper();
        t_range();
        t_gcall();
        t_ext();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end
endmodule